// File: doc/BRIEF.md
# Out-of-Order Issue Queue for Parallel Field Units

This block sits between a host's coprocessor instruction stream and a set of parallel finite-field arithmetic units. Each instruction names one destination register and three or four source registers in the coprocessor's register storage. The three-source form computes a product plus an addend. The four-source form adds an extra term inside the product. Instructions enter an eight-entry queue. A full indication goes back to the host, and the queue hands each instruction to a free arithmetic unit as soon as doing so is safe.

Issue is out of order. In every cycle the dispatcher looks for the oldest queued instruction that has no register conflict with work still in flight or with older instructions still waiting. That instruction goes to the lowest-numbered idle unit, so an independent instruction can overtake a stalled one. Each issued instruction then steps through four phases: one decode cycle, one operand-read cycle per source, execution on its unit, and a write-back slot. The units report the end of execution with a done pulse. Write-back is serialised, one result per cycle. The arithmetic units and the register storage are outside the block.

Top module: `iq_dispatch`

## Requirements
- R1: While reset is held and in the first cycle after it, buf_full, iss_valid, unit_go and wb_valid are all low.
- R2: The queue holds up to 8 instructions. buf_full is high exactly when 8 are held. An enqueue offered while buf_full is high is dropped, and that instruction never issues.
- R3: At most one instruction issues per cycle. iss_valid, iss_unit, iss_dst and iss_four describe it in the issue cycle, and the unit chosen is the lowest-numbered idle one.
- R4: An instruction does not issue while an in-flight or older queued instruction writes one of its sources. A three-source instruction (iss_four=0) uses sources a, b and c. A four-source instruction (iss_four=1) also uses d.
- R5: An instruction does not issue while an in-flight or older queued instruction has the same destination, or reads its destination as a used source.
- R6: Among the queued instructions that R4 and R5 allow, the oldest issues. A younger independent instruction therefore issues ahead of an older blocked one.
- R7: A unit's unit_go bit pulses for exactly one cycle, 2+S cycles after its issue cycle, where S is 3 or 4 sources: one decode cycle plus S read cycles.
- R8: A unit whose unit_done was high in cycle d may write back from cycle d+1 onward. Each cycle, the lowest-indexed waiting unit gets wb_valid, with wb_unit set to that unit and wb_dst set to its destination.
- R9: A unit is idle, and may be issued to again, in the cycle after its write-back.
- R10: No instruction issues while every unit is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Offer an instruction to the queue |
| enq_four | input | 1 | 1: four-source form, 0: three-source form |
| enq_dst | input | RW | Destination register |
| enq_src_a | input | RW | Source register a |
| enq_src_b | input | RW | Source register b |
| enq_src_c | input | RW | Source register c |
| enq_src_d | input | RW | Source register d (four-source form only) |
| buf_full | output | 1 | Queue holds QDEPTH instructions |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_unit | output | UW | Unit receiving it |
| iss_four | output | 1 | Form of the issued instruction |
| iss_dst | output | RW | Destination of the issued instruction |
| unit_go | output | N_UNITS | Per-unit execute start pulse |
| unit_done | input | N_UNITS | Per-unit execute finished pulse |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_unit | output | UW | Unit whose result is written |
| wb_dst | output | RW | Register written |

## Verification
The assertions rely on the done inputs behaving: a unit raises unit_done only while it is executing, at least one cycle after its go pulse, and only once per go. The bench keeps to this because it drives each done pulse from its own record of the go times, with latencies of one cycle or more. It never raises done for an idle unit. Enqueue offers are unconstrained, including offers made while the queue is full, because the block must tolerate them. Register numbers are drawn from a narrow range so that conflicts of all three kinds happen often.

// File: rtl/iq_pkg.sv
// Package iq_pkg
// Shared constants, slot state encoding and the source-usage rule for the
// issue queue. Assumes an instruction entry is packed as
// {src_d, src_c, src_b, src_a, dst, four} with "four" in bit 0.
package iq_pkg;

    localparam int NSRC_BASE = 3;                      // sources of the short form
    localparam int NSRC_MAX  = 4;                      // sources of the long form
    localparam int RCW       = $clog2(NSRC_MAX + 1);   // read counter width

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEC,
        ST_READ,
        ST_LAUNCH,
        ST_EXEC,
        ST_WRITE
    } slot_st_t;

    // True when source k takes part in an instruction of the given form.
    function automatic logic src_used(input logic four, input int k);
        return (k < NSRC_BASE) || four;
    endfunction

endpackage

// File: rtl/iq_queue.sv
// Module iq_queue
// Collapsing instruction buffer. Entry 0 is the oldest. Any one entry may be
// removed per cycle; the younger ones shift down by one. A new entry is
// written behind the survivors. Assumes pop_idx names a valid entry whenever
// pop is high. A push while full is dropped.
module iq_queue #(
    parameter int DEPTH = 8,
    parameter int IW    = 21,
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IW-1:0]    push_data,
    input  logic             pop,
    input  logic [IDXW-1:0]  pop_idx,
    output logic [IW-1:0]    ent [DEPTH],
    output logic [DEPTH-1:0] ent_vld,
    output logic             full
);

    logic [IW-1:0] mem   [DEPTH];
    logic [IW-1:0] mem_n [DEPTH];
    logic [IW-1:0] upper [DEPTH];
    logic [CW-1:0] cnt, cnt_n, base;
    logic          accept;

    assign full   = (cnt == CW'(DEPTH));
    assign accept = push && !full;
    assign base   = cnt - (pop ? CW'(1) : CW'(0));
    assign cnt_n  = base + (accept ? CW'(1) : CW'(0));

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_ent
            // Neighbour that slides into this place on a removal below it.
            if (g < DEPTH - 1) begin : g_up
                assign upper[g] = mem[g+1];
            end else begin : g_top
                assign upper[g] = '0;
            end

            // Next content: shifted survivor or the newly accepted entry.
            always_comb begin
                mem_n[g] = (pop && (IDXW'(g) >= pop_idx)) ? upper[g] : mem[g];
                if (accept && (CW'(g) == base)) begin
                    mem_n[g] = push_data;
                end
            end

            assign ent[g]     = mem[g];
            assign ent_vld[g] = (CW'(g) < cnt);
        end
    endgenerate

    // Register the buffer contents and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            cnt <= cnt_n;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= mem_n[i];
            end
        end
    end

endmodule

// File: rtl/iq_pick.sv
// Module iq_pick
// Issue selection. Finds the oldest queued entry free of conflicts against
// every busy unit and every older queued entry. Three conflict kinds are
// checked: the entry reads a register the other writes, both write the same
// register, or the other reads the register the entry writes. The entry goes
// to the lowest idle unit. Purely combinational.
module iq_pick
    import iq_pkg::*;
#(
    parameter int N_UNITS = 4,
    parameter int DEPTH   = 8,
    parameter int RW      = 4,
    parameter int IW      = 1 + 5 * RW,
    parameter int IDXW    = 3,
    parameter int UW      = 2
) (
    input  logic [IW-1:0]      ent [DEPTH],
    input  logic [DEPTH-1:0]   ent_vld,
    input  logic [N_UNITS-1:0] busy,
    input  logic [IW-1:0]      held [N_UNITS],
    output logic               sel_ok,
    output logic [IDXW-1:0]    sel_idx,
    output logic [UW-1:0]      sel_unit
);

    // True when entry e uses register r as one of its active sources.
    function automatic logic reads_reg(input logic [IW-1:0] e, input logic [RW-1:0] r);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < NSRC_MAX; k++) begin
            if (src_used(e[0], k) && (e[1 + RW*(k+1) +: RW] == r)) begin
                hit = 1'b1;
            end
        end
        return hit;
    endfunction

    // True when younger entry y must wait for older entry o.
    function automatic logic clash(input logic [IW-1:0] y, input logic [IW-1:0] o);
        return reads_reg(y, o[1 +: RW])
            || (y[1 +: RW] == o[1 +: RW])
            || reads_reg(o, y[1 +: RW]);
    endfunction

    logic             free_found;
    logic             found;
    logic [DEPTH-1:0] blocked;

    // Lowest idle unit.
    always_comb begin
        free_found = 1'b0;
        sel_unit   = '0;
        for (int u = 0; u < N_UNITS; u++) begin
            if (!busy[u] && !free_found) begin
                free_found = 1'b1;
                sel_unit   = UW'(u);
            end
        end
    end

    // Per-entry blocking against busy units and older waiting entries.
    always_comb begin
        blocked = '0;
        for (int k = 0; k < DEPTH; k++) begin
            for (int u = 0; u < N_UNITS; u++) begin
                if (busy[u] && clash(ent[k], held[u])) begin
                    blocked[k] = 1'b1;
                end
            end
            for (int j = 0; j < DEPTH; j++) begin
                if ((j < k) && ent_vld[j] && clash(ent[k], ent[j])) begin
                    blocked[k] = 1'b1;
                end
            end
        end
    end

    // Oldest unblocked entry wins.
    always_comb begin
        found   = 1'b0;
        sel_idx = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (!found && ent_vld[k] && !blocked[k]) begin
                found   = 1'b1;
                sel_idx = IDXW'(k);
            end
        end
    end

    assign sel_ok = found && free_found;

endmodule

// File: rtl/iq_slot.sv
// Module iq_slot
// Stage tracker for one arithmetic unit. It holds the issued entry and walks
// it through decode (1 cycle), operand read (one cycle per active source),
// a one-cycle launch pulse, execution until done, and write-back until
// granted. Assumes done arrives only after launch and once per launch.
module iq_slot
    import iq_pkg::*;
#(
    parameter int RW = 4,
    parameter int IW = 1 + 5 * RW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] start_ent,
    input  logic          done,
    input  logic          grant,
    output logic          busy,
    output logic [IW-1:0] held,
    output logic          go,
    output logic          want_wb
);

    slot_st_t       state;
    logic [RCW-1:0] rcnt;

    // Advance the stage sequence of the held instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rcnt  <= '0;
            held  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        held  <= start_ent;
                        state <= ST_DEC;
                    end
                end
                ST_DEC: begin
                    rcnt  <= held[0] ? RCW'(NSRC_MAX - 1) : RCW'(NSRC_BASE - 1);
                    state <= ST_READ;
                end
                ST_READ: begin
                    if (rcnt == '0) begin
                        state <= ST_LAUNCH;
                    end else begin
                        rcnt <= rcnt - RCW'(1);
                    end
                end
                ST_LAUNCH: begin
                    state <= done ? ST_WRITE : ST_EXEC;
                end
                ST_EXEC: begin
                    if (done) begin
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (grant) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign go      = (state == ST_LAUNCH);
    assign want_wb = (state == ST_WRITE);

endmodule

// File: rtl/iq_wb_arb.sv
// Module iq_wb_arb
// Fixed-priority write-back arbiter: one grant per cycle, lowest index first.
// Purely combinational.
module iq_wb_arb #(
    parameter int N_UNITS = 4,
    parameter int UW      = 2
) (
    input  logic [N_UNITS-1:0] want,
    output logic [N_UNITS-1:0] grant,
    output logic               wb_valid,
    output logic [UW-1:0]      wb_unit
);

    // Grant the lowest requesting unit.
    always_comb begin
        grant    = '0;
        wb_valid = 1'b0;
        wb_unit  = '0;
        for (int u = 0; u < N_UNITS; u++) begin
            if (want[u] && !wb_valid) begin
                wb_valid = 1'b1;
                wb_unit  = UW'(u);
                grant[u] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/iq_dispatch.sv
// Module iq_dispatch (top)
// Instruction queue and out-of-order dispatcher for N_UNITS field units.
// Instructions are buffered, checked for register conflicts, issued one per
// cycle to the lowest idle unit, sequenced through decode/read/execute, and
// written back one per cycle. Assumes the units obey the go/done handshake.
module iq_dispatch
    import iq_pkg::*;
#(
    parameter int N_UNITS = 4,
    parameter int QDEPTH  = 8,
    parameter int RW      = 4,
    localparam int UW     = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
    localparam int IW     = 1 + 5 * RW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enq_valid,
    input  logic               enq_four,
    input  logic [RW-1:0]      enq_dst,
    input  logic [RW-1:0]      enq_src_a,
    input  logic [RW-1:0]      enq_src_b,
    input  logic [RW-1:0]      enq_src_c,
    input  logic [RW-1:0]      enq_src_d,
    output logic               buf_full,
    output logic               iss_valid,
    output logic [UW-1:0]      iss_unit,
    output logic               iss_four,
    output logic [RW-1:0]      iss_dst,
    output logic [N_UNITS-1:0] unit_go,
    input  logic [N_UNITS-1:0] unit_done,
    output logic               wb_valid,
    output logic [UW-1:0]      wb_unit,
    output logic [RW-1:0]      wb_dst
);

    localparam int IDXW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

    logic [IW-1:0]      enq_ent;
    logic [IW-1:0]      q_ent [QDEPTH];
    logic [QDEPTH-1:0]  q_vld;
    logic               sel_ok;
    logic [IDXW-1:0]    sel_idx;
    logic [UW-1:0]      sel_unit;
    logic [IW-1:0]      sel_ent;
    logic [N_UNITS-1:0] slot_busy;
    logic [N_UNITS-1:0] slot_want;
    logic [N_UNITS-1:0] slot_grant;
    logic [IW-1:0]      slot_held [N_UNITS];

    assign enq_ent = {enq_src_d, enq_src_c, enq_src_b, enq_src_a, enq_dst, enq_four};

    iq_queue #(.DEPTH(QDEPTH), .IW(IW)) i_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (enq_valid),
        .push_data (enq_ent),
        .pop       (sel_ok),
        .pop_idx   (sel_idx),
        .ent       (q_ent),
        .ent_vld   (q_vld),
        .full      (buf_full)
    );

    iq_pick #(
        .N_UNITS (N_UNITS),
        .DEPTH   (QDEPTH),
        .RW      (RW),
        .IW      (IW),
        .IDXW    (IDXW),
        .UW      (UW)
    ) i_pick (
        .ent      (q_ent),
        .ent_vld  (q_vld),
        .busy     (slot_busy),
        .held     (slot_held),
        .sel_ok   (sel_ok),
        .sel_idx  (sel_idx),
        .sel_unit (sel_unit)
    );

    assign sel_ent   = q_ent[sel_idx];
    assign iss_valid = sel_ok;
    assign iss_unit  = sel_unit;
    assign iss_four  = sel_ent[0];
    assign iss_dst   = sel_ent[1 +: RW];

    genvar u;
    generate
        for (u = 0; u < N_UNITS; u++) begin : g_slot
            iq_slot #(.RW(RW), .IW(IW)) i_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .start     (sel_ok && (sel_unit == UW'(u))),
                .start_ent (sel_ent),
                .done      (unit_done[u]),
                .grant     (slot_grant[u]),
                .busy      (slot_busy[u]),
                .held      (slot_held[u]),
                .go        (unit_go[u]),
                .want_wb   (slot_want[u])
            );
        end
    endgenerate

    iq_wb_arb #(.N_UNITS(N_UNITS), .UW(UW)) i_wb (
        .want     (slot_want),
        .grant    (slot_grant),
        .wb_valid (wb_valid),
        .wb_unit  (wb_unit)
    );

    assign wb_dst = slot_held[wb_unit][1 +: RW];

endmodule

// File: rtl/iq_dispatch_chk.sv
// Module iq_dispatch_chk
// Temporal checks on the dispatcher, attached to every iq_dispatch instance
// by the bind at the end of this file. Assumes unit_done follows unit_go.
module iq_dispatch_chk
    import iq_pkg::*;
#(
    parameter int N_UNITS = 4,
    parameter int RW      = 4,
    parameter int IW      = 1 + 5 * RW,
    parameter int UW      = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               buf_full,
    input logic               iss_valid,
    input logic [UW-1:0]      iss_unit,
    input logic [N_UNITS-1:0] unit_go,
    input logic               wb_valid,
    input logic [UW-1:0]      wb_unit,
    input logic [N_UNITS-1:0] slot_busy,
    input logic [N_UNITS-1:0] slot_want,
    input logic [IW-1:0]      sel_ent,
    input logic [IW-1:0]      slot_held [N_UNITS]
);

    // True when entry e uses register r as an active source.
    function automatic logic uses(input logic [IW-1:0] e, input logic [RW-1:0] r);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < NSRC_MAX; k++) begin
            if (src_used(e[0], k) && (e[1 + RW*(k+1) +: RW] == r)) begin
                hit = 1'b1;
            end
        end
        return hit;
    endfunction

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!buf_full && !wb_valid && (unit_go == '0)));

    a_r10_issue_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !slot_busy[iss_unit]);

    a_r9_wb_frees_unit: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !slot_busy[$past(wb_unit)]);

    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !iss_valid) |=> buf_full);

    genvar u;
    generate
        for (u = 0; u < N_UNITS; u++) begin : g_unit
            a_r7_go_single: assert property (@(posedge clk) disable iff (!rst_n)
                unit_go[u] |=> !unit_go[u]);

            a_r8_low_first: assert property (@(posedge clk) disable iff (!rst_n)
                (slot_want[u] && wb_valid) |-> (wb_unit <= UW'(u)));

            a_r4_no_raw_issue: assert property (@(posedge clk) disable iff (!rst_n)
                (iss_valid && slot_busy[u]) |-> !uses(sel_ent, slot_held[u][1 +: RW]));
        end
    endgenerate

endmodule

bind iq_dispatch iq_dispatch_chk #(
    .N_UNITS (N_UNITS),
    .RW      (RW),
    .IW      (IW),
    .UW      (UW)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_full  (buf_full),
    .iss_valid (iss_valid),
    .iss_unit  (iss_unit),
    .unit_go   (unit_go),
    .wb_valid  (wb_valid),
    .wb_unit   (wb_unit),
    .slot_busy (slot_busy),
    .slot_want (slot_want),
    .sel_ent   (sel_ent),
    .slot_held (slot_held)
);

// File: tb/test_iq_dispatch.sv
// Bench for iq_dispatch: directed corner cases plus seeded random traffic,
// compared every cycle against a behavioural model built from the brief.
module test_iq_dispatch;

    localparam int N  = 4;
    localparam int D  = 8;
    localparam int RW = 4;
    localparam int UW = 2;

    typedef struct {
        bit four;
        int dst;
        int src[4];
    } rec_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enq_valid = 1'b0;
    logic          enq_four = 1'b0;
    logic [RW-1:0] enq_dst = '0, enq_src_a = '0, enq_src_b = '0, enq_src_c = '0, enq_src_d = '0;
    logic          buf_full, iss_valid, iss_four, wb_valid;
    logic [UW-1:0] iss_unit, wb_unit;
    logic [RW-1:0] iss_dst, wb_dst;
    logic [N-1:0]  unit_go;
    logic [N-1:0]  unit_done = '0;

    always #2 clk = ~clk;

    iq_dispatch #(.N_UNITS(N), .QDEPTH(D), .RW(RW)) i_iq_dispatch (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_four(enq_four),
        .enq_dst(enq_dst), .enq_src_a(enq_src_a), .enq_src_b(enq_src_b),
        .enq_src_c(enq_src_c), .enq_src_d(enq_src_d), .buf_full(buf_full),
        .iss_valid(iss_valid), .iss_unit(iss_unit), .iss_four(iss_four),
        .iss_dst(iss_dst), .unit_go(unit_go), .unit_done(unit_done),
        .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_dst(wb_dst)
    );

    int   checks = 0, fails = 0, cyc = 0;
    rec_t mq[D];
    int   mcnt = 0;
    rec_t ut[N];
    bit   ub[N], u_gone[N], u_wait[N];
    int   u_iss[N], u_done_at[N];
    int   lat_lo = 1, lat_hi = 6;
    bit   hold_done = 0;
    int   hist[$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic bit rd(input rec_t r, input int reg_no);
        for (int k = 0; k < 4; k++) begin
            if ((k < 3 || r.four) && r.src[k] == reg_no) return 1;
        end
        return 0;
    endfunction

    function automatic bit clash(input rec_t y, input rec_t o);
        return rd(y, o.dst) || (y.dst == o.dst) || rd(o, y.dst);
    endfunction

    function automatic rec_t mk(input bit four, input int dst, input int a, input int b, input int c, input int d);
        rec_t r;
        r.four = four; r.dst = dst;
        r.src[0] = a; r.src[1] = b; r.src[2] = c; r.src[3] = d;
        return r;
    endfunction

    function automatic rec_t rnd_rec(input int span);
        return mk(1'($urandom % 2), int'($urandom % span), int'($urandom % span),
                  int'($urandom % span), int'($urandom % span), int'($urandom % span));
    endfunction

    // One cycle: check outputs against the model, then drive the next inputs.
    task automatic step(input bit do_enq, input rec_t e, input bit release_all);
        int      fu, ek, ew;
        bit      blk, full_now;
        bit [N-1:0] eg;
        logic [N-1:0] dn;
        @(negedge clk);
        fu = -1;
        for (int u = 0; u < N; u++) if (!ub[u] && fu < 0) fu = u;
        ek = -1;
        if (fu >= 0) begin
            for (int k = 0; k < mcnt; k++) begin
                blk = 0;
                for (int u = 0; u < N; u++) if (ub[u] && clash(mq[k], ut[u])) blk = 1;
                for (int j = 0; j < k; j++) if (clash(mq[k], mq[j])) blk = 1;
                if (!blk && ek < 0) ek = k;
            end
        end
        full_now = (mcnt == D);
        chk(buf_full == full_now, "R2", "buf_full", int'(buf_full), int'(full_now));
        // R3 R4 R5 R6 R10: issue presence and choice
        chk(iss_valid == (ek >= 0), "R3/R4/R5/R10", "iss_valid", int'(iss_valid), int'(ek >= 0));
        if (iss_valid && ek >= 0) begin
            chk(int'(iss_unit) == fu, "R3", "iss_unit", int'(iss_unit), fu);
            chk(int'(iss_dst) == mq[ek].dst, "R6", "iss_dst", int'(iss_dst), mq[ek].dst);
            chk(iss_four == mq[ek].four, "R6", "iss_four", int'(iss_four), int'(mq[ek].four));
            hist.push_back(int'(iss_dst));
        end
        for (int u = 0; u < N; u++)
            eg[u] = ub[u] && !u_gone[u] && (cyc == u_iss[u] + 2 + (ut[u].four ? 4 : 3));
        chk(unit_go == eg, "R7", "unit_go", int'(unit_go), int'(eg));
        ew = -1;
        for (int u = 0; u < N; u++) if (ub[u] && u_wait[u] && ew < 0) ew = u;
        chk(wb_valid == (ew >= 0), "R8", "wb_valid", int'(wb_valid), int'(ew >= 0));
        if (wb_valid && ew >= 0) begin
            chk(int'(wb_unit) == ew, "R8", "wb_unit", int'(wb_unit), ew);
            chk(int'(wb_dst) == ut[ew].dst, "R8", "wb_dst", int'(wb_dst), ut[ew].dst);
        end
        // model update: R9 frees the unit after its write-back
        if (ew >= 0) begin
            ub[ew] = 0; u_wait[ew] = 0; u_gone[ew] = 0;
        end
        if (ek >= 0) begin
            ut[fu] = mq[ek]; ub[fu] = 1; u_iss[fu] = cyc;
            u_gone[fu] = 0; u_wait[fu] = 0; u_done_at[fu] = -1;
            for (int k = ek; k < mcnt - 1; k++) mq[k] = mq[k+1];
            mcnt--;
        end
        for (int u = 0; u < N; u++) begin
            if (eg[u]) begin
                u_gone[u] = 1;
                u_done_at[u] = hold_done ? -1 : cyc + lat_lo + int'($urandom % (lat_hi - lat_lo + 1));
            end
            if (release_all && ub[u] && u_gone[u] && !u_wait[u] && u_done_at[u] < 0 && !eg[u])
                u_done_at[u] = cyc;
        end
        dn = '0;
        for (int u = 0; u < N; u++) begin
            if (ub[u] && u_gone[u] && !u_wait[u] && u_done_at[u] == cyc) begin
                dn[u] = 1'b1; u_wait[u] = 1;
            end
        end
        unit_done <= dn;
        enq_valid <= do_enq;
        enq_four  <= e.four;
        enq_dst   <= RW'(e.dst);
        enq_src_a <= RW'(e.src[0]);
        enq_src_b <= RW'(e.src[1]);
        enq_src_c <= RW'(e.src[2]);
        enq_src_d <= RW'(e.src[3]);
        if (do_enq && !full_now) begin
            mq[mcnt] = e; mcnt++;
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, mk(0, 0, 0, 0, 0, 0), 0);
    endtask

    function automatic int pos_of(input int dst);
        foreach (hist[i]) if (hist[i] == dst) return i;
        return -1;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int p2, p3;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!buf_full, "R1", "buf_full", int'(buf_full), 0);
        chk(!iss_valid, "R1", "iss_valid", int'(iss_valid), 0);
        chk(unit_go == '0, "R1", "unit_go", int'(unit_go), 0);
        chk(!wb_valid, "R1", "wb_valid", int'(wb_valid), 0);
        rst_n = 1'b1;

        // R2: fill with long latency; two offers while full are dropped
        lat_lo = 40; lat_hi = 40;
        for (int i = 0; i < 14; i++) step(1, mk(i % 2, i, 14, 15, 14, 15), 0);
        step(0, mk(0, 0, 0, 0, 0, 0), 0);
        chk(buf_full == 1'b1, "R2", "buf_full after overfill", int'(buf_full), 1);
        chk(mcnt == 8, "R2", "model occupancy", mcnt, 8);
        idle(160);

        // R6: independent younger instruction overtakes a RAW-blocked one
        lat_lo = 10; lat_hi = 10;
        hist.delete();
        step(1, mk(0, 1, 8, 9, 10, 0), 0);
        step(1, mk(0, 2, 1, 9, 10, 0), 0);
        step(1, mk(1, 3, 11, 12, 13, 12), 0);
        idle(60);
        p2 = pos_of(2); p3 = pos_of(3);
        chk(p3 >= 0 && p3 < p2, "R6", "bypass order (pos3 vs pos2)", p3, p2 - 1);

        // R5: WAW and WAR against an in-flight instruction
        hist.delete();
        step(1, mk(1, 5, 8, 9, 10, 11), 0);
        step(1, mk(0, 5, 12, 13, 14, 0), 0);
        step(1, mk(0, 9, 12, 13, 14, 0), 0);
        step(1, mk(0, 6, 12, 13, 14, 0), 0);
        idle(80);
        chk(pos_of(6) < pos_of(9), "R5", "WAR-blocked after free one", pos_of(6), pos_of(9) - 1);

        // R8: four units complete together; write-back in ascending order
        hold_done = 1;
        for (int i = 0; i < 4; i++) step(1, mk(i % 2, i, 12, 13, 14, 15), 0);
        idle(14);
        hold_done = 0; lat_lo = 1; lat_hi = 6;
        step(0, mk(0, 0, 0, 0, 0, 0), 1);
        idle(20);

        // Random traffic over a narrow register range
        for (int i = 0; i < 3000; i++) step(($urandom % 10) < 6, rnd_rec(8), 0);
        idle(120);
        chk(mcnt == 0, "R3", "drained queue", mcnt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule